// File: doc/BRIEF.md
# Multi-Mode Multiplier Arithmetic Slice

This slice holds four signed 18x18 multipliers and, selected once at elaboration, turns their products into one of four kinds of result: the products themselves, four running accumulations, two sums of a product pair, or one sum of all four products. In the plain product mode each 18x18 multiplier may instead work as two independent 9x9 multipliers, so the slice delivers eight small products.

A selection stage picks the result kind for each of four output lanes. A per-lane output register can then be fitted behind it, also chosen at elaboration. Each lane has its own enable and its own clear. A single add/subtract control sets the sign of the second term in the pair sums and the direction of accumulation. A load control restarts the accumulators from the current product.

Top module: `dsp_slice`

## Requirements
- R1: With MODE=0 (plain product) and SPLIT=0, lane k carries the signed product of operand slices a_i[18k+17:18k] and b_i[18k+17:18k], sign-extended to ACC_W bits.
- R2: With MODE=0 and SPLIT=1, lane k bits [17:0] hold the signed product of the low 9-bit halves of its operands, bits [35:18] hold the signed product of the high 9-bit halves, and the bits above 35 are zero.
- R3: With MODE=1 (accumulate), at each rising edge where lane_en_i[k] is high and no clear or load applies, accumulator k adds its lane's product (sub_i=0) or subtracts it (sub_i=1). While lane_en_i[k] is low it holds its value. The accumulator drives lane k.
- R4: With MODE=1, an enabled edge with acc_clr_i high loads the accumulator with the current product, whatever the previous sum was.
- R5: Accumulation wraps modulo 2^ACC_W, with no saturation.
- R6: With MODE=2 (pair sum), lane 0 is p0+p1 (or p0-p1 when sub_i=1), lane 1 is p2+p3 (or p2-p3), and lanes 2 and 3 are zero. Here pk is the signed 18x18 product of lane k.
- R7: With MODE=3 (quad sum), lane 0 is (p0 +/- p1) + (p2 +/- p3), with the sign set by sub_i, computed without overflow. Lanes 1 to 3 are zero.
- R8: When bit k of OUT_REG is 0, lane k follows its inputs in the same cycle, with no clock edge needed.
- R9: When bit k of OUT_REG is 1, lane k loads the selected result at a rising edge with lane_en_i[k] high, and holds while it is low.
- R10: lane_clr_i[k] high at a rising edge zeroes the lane k output register and accumulator k, and takes priority over enable and load.
- R11: rst_n low at a rising edge zeroes every output register and accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | 4*OP_W | Four first operands, lane k at bits [OP_W*k +: OP_W] |
| b_i | input | 4*OP_W | Four second operands, same packing as a_i |
| sub_i | input | 1 | 1 = subtract second term / subtract product from accumulator |
| acc_clr_i | input | 1 | Load accumulators with the product instead of the sum |
| lane_en_i | input | 4 | Per-lane clock enable for registers and accumulators |
| lane_clr_i | input | 4 | Per-lane synchronous clear |
| y_o | output | 4*ACC_W | Four lane results, lane k at bits [ACC_W*k +: ACC_W] |

## Verification
The assertions assume that ACC_W is at least 2*OP_W+2, so that sign extension and the quad sum fit. They also assume that the control inputs are settled at each clock edge. The bench drives all inputs on the falling edge, well away from the sampling edge. It keeps ACC_W at 52 for most instances and 38 for the wraparound instance, both of which satisfy the width bound. Operand patterns include the most negative value, -1 and mixed-sign 9-bit halves.

// File: rtl/dsp_pkg.sv
// Shared definitions for the multiplier slice: mode encoding and lane count.
package dsp_pkg;
    typedef enum logic [1:0] {
        MODE_SIMPLE = 2'd0,
        MODE_MAC    = 2'd1,
        MODE_ADD2   = 2'd2,
        MODE_ADD4   = 2'd3
    } dsp_mode_e;

    localparam int NUM_LANES = 4;
endpackage

// File: rtl/dsp_mult_lane.sv
// One multiplier lane. It forms the full signed OP_W x OP_W product and,
// when SPLIT is set, two independent signed products of the operand halves,
// packed {high, low}.
// Assumes OP_W is even.
module dsp_mult_lane #(
    parameter int OP_W  = 18,
    parameter bit SPLIT = 1'b0
) (
    input  logic [OP_W-1:0]          a_i,
    input  logic [OP_W-1:0]          b_i,
    output logic signed [2*OP_W-1:0] prod_o,
    output logic [2*OP_W-1:0]        pair_o
);
    localparam int HALF_W = OP_W / 2;

    logic signed [2*OP_W-1:0] a_ext, b_ext;

    // full-width signed product
    always_comb begin
        a_ext  = {{OP_W{a_i[OP_W-1]}}, a_i};
        b_ext  = {{OP_W{b_i[OP_W-1]}}, b_i};
        prod_o = a_ext * b_ext;
    end

    generate
        if (SPLIT) begin : g_split
            logic signed [2*HALF_W-1:0] al, bl, ah, bh, lo, hi;
            // two independent half-width signed products
            always_comb begin
                al = {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
                bl = {{HALF_W{b_i[HALF_W-1]}}, b_i[HALF_W-1:0]};
                ah = {{HALF_W{a_i[OP_W-1]}}, a_i[OP_W-1:HALF_W]};
                bh = {{HALF_W{b_i[OP_W-1]}}, b_i[OP_W-1:HALF_W]};
                lo = al * bl;
                hi = ah * bh;
                pair_o = {hi, lo};
            end
        end else begin : g_nosplit
            // no half products in this variant
            always_comb pair_o = '0;
        end
    endgenerate
endmodule

// File: rtl/dsp_accum.sv
// Per-lane accumulator. It adds or subtracts a sign-extended product on
// enabled edges, loads the product on request and clears on request.
// Assumes ACC_W > P_W. Wraps modulo 2^ACC_W.
module dsp_accum #(
    parameter int ACC_W = 52,
    parameter int P_W   = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 clr_i,
    input  logic                 load_i,
    input  logic                 sub_i,
    input  logic signed [P_W-1:0] p_i,
    output logic [ACC_W-1:0]     acc_o
);
    logic [ACC_W-1:0] p_ext;

    // sign-extend the product to accumulator width
    always_comb p_ext = {{(ACC_W-P_W){p_i[P_W-1]}}, p_i};

    // running sum with clear > load > add/sub priority
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_o <= '0;
        else if (clr_i)  acc_o <= '0;
        else if (en_i) begin
            if (load_i)      acc_o <= p_ext;
            else if (sub_i)  acc_o <= acc_o - p_ext;
            else             acc_o <= acc_o + p_ext;
        end
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0)); // R10
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(acc_o)); // R3
    AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && load_i && !clr_i) |=> (acc_o == $past(p_ext))); // R4
endmodule

// File: rtl/dsp_slice.sv
// Multi-mode multiplier slice: four multiplier lanes, a mode-fixed result
// selector and per-lane optional output registers.
// Assumes ACC_W >= 2*OP_W+2 so the quad sum cannot overflow.
module dsp_slice #(
    parameter dsp_pkg::dsp_mode_e MODE = dsp_pkg::MODE_SIMPLE,
    parameter bit                 SPLIT   = 1'b0,
    parameter logic [3:0]         OUT_REG = 4'b0000,
    parameter int                 OP_W    = 18,
    parameter int                 ACC_W   = 52
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4*OP_W-1:0]    a_i,
    input  logic [4*OP_W-1:0]    b_i,
    input  logic                 sub_i,
    input  logic                 acc_clr_i,
    input  logic [3:0]           lane_en_i,
    input  logic [3:0]           lane_clr_i,
    output logic [4*ACC_W-1:0]   y_o
);
    localparam int NL  = dsp_pkg::NUM_LANES;
    localparam int P_W = 2 * OP_W;
    localparam int PAD = ACC_W - P_W;

    logic signed [P_W-1:0]   prod [NL];
    logic [P_W-1:0]          pair [NL];
    logic signed [ACC_W-1:0] ext  [NL];
    logic [ACC_W-1:0]        acc  [NL];
    logic [ACC_W-1:0]        sel  [NL];
    logic signed [ACC_W-1:0] sum01, sum23;

    generate
        for (genvar k = 0; k < NL; k++) begin : g_lane
            dsp_mult_lane #(.OP_W(OP_W), .SPLIT(SPLIT)) u_mult (
                .a_i   (a_i[k*OP_W +: OP_W]),
                .b_i   (b_i[k*OP_W +: OP_W]),
                .prod_o(prod[k]),
                .pair_o(pair[k])
            );

            // sign-extend the lane product
            always_comb ext[k] = {{PAD{prod[k][P_W-1]}}, prod[k]};

            dsp_accum #(.ACC_W(ACC_W), .P_W(P_W)) u_acc (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (lane_en_i[k]),
                .clr_i (lane_clr_i[k]),
                .load_i(acc_clr_i),
                .sub_i (sub_i),
                .p_i   (prod[k]),
                .acc_o (acc[k])
            );
        end
    endgenerate

    // pair sums shared by the two adder modes
    always_comb begin
        sum01 = sub_i ? (ext[0] - ext[1]) : (ext[0] + ext[1]);
        sum23 = sub_i ? (ext[2] - ext[3]) : (ext[2] + ext[3]);
    end

    // output selection by the elaboration-time mode
    always_comb begin
        for (int k = 0; k < NL; k++) sel[k] = '0;
        case (MODE)
            dsp_pkg::MODE_SIMPLE: begin
                for (int k = 0; k < NL; k++)
                    sel[k] = SPLIT ? {{PAD{1'b0}}, pair[k]} : ext[k];
            end
            dsp_pkg::MODE_MAC: begin
                for (int k = 0; k < NL; k++) sel[k] = acc[k];
            end
            dsp_pkg::MODE_ADD2: begin
                sel[0] = sum01;
                sel[1] = sum23;
            end
            default: begin
                sel[0] = sum01 + sum23;
            end
        endcase
    end

    generate
        for (genvar k = 0; k < NL; k++) begin : g_out
            if (OUT_REG[k]) begin : g_reg
                logic [ACC_W-1:0] q;
                // per-lane output register: clear > enable
                always_ff @(posedge clk) begin
                    if (!rst_n)             q <= '0;
                    else if (lane_clr_i[k]) q <= '0;
                    else if (lane_en_i[k])  q <= sel[k];
                end
                assign y_o[k*ACC_W +: ACC_W] = q;

                AST_LANE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                    lane_clr_i[k] |=> (y_o[k*ACC_W +: ACC_W] == '0)); // R10
                AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    (!lane_en_i[k] && !lane_clr_i[k]) |=> $stable(y_o[k*ACC_W +: ACC_W])); // R9
            end else begin : g_byp
                assign y_o[k*ACC_W +: ACC_W] = sel[k];
            end
        end
    endgenerate
endmodule

// File: tb/tb_dsp_slice.sv
module tb_dsp_slice;
    localparam int LW = 52;
    localparam int WW = 38;
    localparam logic [3:0] OREG = 4'b0101;

    typedef struct packed {
        logic             sub;
        logic [3:0][17:0] a;
        logic [3:0][17:0] b;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, {18'd3, 18'd2, 18'd1, 18'd5}, {18'd13, 18'd11, 18'd9, 18'd7}},
        '{1'b1, {18'h3FFFF, 18'h20000, 18'h1FFFF, 18'h12345}, {18'h3FFFF, 18'h20000, 18'h1FFFF, 18'h3FE07}},
        '{1'b0, {18'h20000, 18'h20000, 18'h20000, 18'h20000}, {18'h20000, 18'h20000, 18'h20000, 18'h20000}},
        '{1'b1, {18'h3FE07, 18'h001FF, 18'h3FF00, 18'h0ABCD}, {18'h1C0FF, 18'h3FFFF, 18'h00200, 18'h2F00F}},
        '{1'b0, {18'd0, 18'd0, 18'd0, 18'd0}, {18'h01234, 18'h3FFFF, 18'h20000, 18'd9}},
        '{1'b1, {18'h1FFFF, 18'h20000, 18'h1FFFF, 18'h20000}, {18'h20000, 18'h1FFFF, 18'h20000, 18'h1FFFF}}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [71:0] a = '0, b = '0;
    logic sub = 1'b0, acc_clr = 1'b0;
    logic [3:0] lane_en = '0, lane_clr = '0;
    logic [4*LW-1:0] y_s, y_sp, y_a2, y_a4, y_m;
    logic [4*WW-1:0] y_w;
    int nchk = 0, nfail = 0;

    logic [LW-1:0] rq [4][4];
    logic [LW-1:0] am [4];
    logic [WW-1:0] aw [4];

    always #5 clk = ~clk;

    dsp_slice #(.MODE(dsp_pkg::MODE_SIMPLE), .SPLIT(1'b0), .OUT_REG(OREG)) dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sub_i(sub), .acc_clr_i(acc_clr),
        .lane_en_i(lane_en), .lane_clr_i(lane_clr), .y_o(y_s));
    dsp_slice #(.MODE(dsp_pkg::MODE_SIMPLE), .SPLIT(1'b1), .OUT_REG(OREG)) dut_sp (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sub_i(sub), .acc_clr_i(acc_clr),
        .lane_en_i(lane_en), .lane_clr_i(lane_clr), .y_o(y_sp));
    dsp_slice #(.MODE(dsp_pkg::MODE_ADD2), .OUT_REG(OREG)) dut_a2 (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sub_i(sub), .acc_clr_i(acc_clr),
        .lane_en_i(lane_en), .lane_clr_i(lane_clr), .y_o(y_a2));
    dsp_slice #(.MODE(dsp_pkg::MODE_ADD4), .OUT_REG(OREG)) dut_a4 (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sub_i(sub), .acc_clr_i(acc_clr),
        .lane_en_i(lane_en), .lane_clr_i(lane_clr), .y_o(y_a4));
    dsp_slice #(.MODE(dsp_pkg::MODE_MAC), .OUT_REG(4'b0000)) dut_mac (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sub_i(sub), .acc_clr_i(acc_clr),
        .lane_en_i(lane_en), .lane_clr_i(lane_clr), .y_o(y_m));
    dsp_slice #(.MODE(dsp_pkg::MODE_MAC), .OUT_REG(4'b0000), .ACC_W(WW)) dut_macw (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .sub_i(sub), .acc_clr_i(acc_clr),
        .lane_en_i(lane_en), .lane_clr_i(lane_clr), .y_o(y_w));

    task automatic check(input logic [LW-1:0] act, input logic [LW-1:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint prod(input logic [17:0] x, input logic [17:0] y);
        return longint'($signed(x)) * longint'($signed(y));
    endfunction

    function automatic longint hprod(input logic [8:0] x, input logic [8:0] y);
        return longint'($signed(x)) * longint'($signed(y));
    endfunction

    // expected selected result for the non-accumulating instances
    function automatic logic [LW-1:0] comb_exp(input int m, input int k, input vec_t v);
        longint p [4];
        longint s01, s23;
        logic [17:0] lo, hi;
        for (int i = 0; i < 4; i++) p[i] = prod(v.a[i], v.b[i]);
        s01 = v.sub ? p[0] - p[1] : p[0] + p[1];
        s23 = v.sub ? p[2] - p[3] : p[2] + p[3];
        case (m)
            0: return LW'(p[k]);
            1: begin
                lo = 18'(hprod(v.a[k][8:0], v.b[k][8:0]));
                hi = 18'(hprod(v.a[k][17:9], v.b[k][17:9]));
                return {16'b0, hi, lo};
            end
            2: return (k == 0) ? LW'(s01) : (k == 1) ? LW'(s23) : '0;
            default: return (k == 0) ? LW'(s01 + s23) : '0;
        endcase
    endfunction

    function automatic logic [LW-1:0] get(input int m, input int k);
        case (m)
            0: return y_s[k*LW +: LW];
            1: return y_sp[k*LW +: LW];
            2: return y_a2[k*LW +: LW];
            default: return y_a4[k*LW +: LW];
        endcase
    endfunction

    function automatic string tagof(input int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // drive one vector, check bypassed lanes before the edge, then all lanes after
    task automatic apply(input vec_t v, input logic ld, input logic [3:0] en, input logic [3:0] clr);
        string t;
        logic [LW-1:0] pk;
        @(negedge clk);
        a = v.a; b = v.b; sub = v.sub; acc_clr = ld; lane_en = en; lane_clr = clr;
        #1;
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 4; k++)
                if (!OREG[k]) check(get(m, k), comb_exp(m, k, v), "R8");
        @(posedge clk);
        #1;
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 4; k++) begin
                if (OREG[k]) begin
                    if (!rst_n || clr[k]) rq[m][k] = '0;
                    else if (en[k])       rq[m][k] = comb_exp(m, k, v);
                    t = !rst_n ? "R11" : clr[k] ? "R10" : !en[k] ? "R9" : tagof(m);
                    check(get(m, k), rq[m][k], t);
                end else begin
                    check(get(m, k), comb_exp(m, k, v), tagof(m));
                end
            end
        for (int k = 0; k < 4; k++) begin
            pk = LW'(prod(v.a[k], v.b[k]));
            if (!rst_n || clr[k]) begin
                am[k] = '0; aw[k] = '0;
            end else if (en[k]) begin
                if (ld)         begin am[k] = pk;         aw[k] = WW'(pk);         end
                else if (v.sub) begin am[k] = am[k] - pk; aw[k] = aw[k] - WW'(pk); end
                else            begin am[k] = am[k] + pk; aw[k] = aw[k] + WW'(pk); end
            end
            t = !rst_n ? "R11" : clr[k] ? "R10" : (ld && en[k]) ? "R4" : "R3";
            check(y_m[k*LW +: LW], am[k], t);
            check(LW'(y_w[k*WW +: WW]), LW'(aw[k]), "R5");
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
        $finish;
    end

    initial begin
        for (int m = 0; m < 4; m++) for (int k = 0; k < 4; k++) rq[m][k] = '0;
        for (int k = 0; k < 4; k++) begin am[k] = '0; aw[k] = '0; end
        // R11: reset with live inputs leaves registers and accumulators at zero
        apply(VEC[1], 1'b0, 4'b1111, 4'b0000);
        apply(VEC[3], 1'b0, 4'b1111, 4'b0000);
        @(negedge clk); rst_n = 1'b1;
        // table walk: first vector loads the accumulators (R4), the rest accumulate (R3)
        for (int i = 0; i < 6; i++) apply(VEC[i], (i == 0), 4'b1111, 4'b0000);
        // R9 hold with enables low; R3 accumulators hold too
        apply(VEC[3], 1'b0, 4'b0000, 4'b0000);
        // R10 clear overrides enable and load
        apply(VEC[1], 1'b1, 4'b1111, 4'b1111);
        // mixed per-lane enable and clear
        apply(VEC[5], 1'b0, 4'b1010, 4'b0101);
        apply(VEC[2], 1'b0, 4'b1111, 4'b0000);
        // R5 wraparound: eight times 2^34 reaches 2^37 in a 38-bit accumulator
        apply(VEC[2], 1'b1, 4'b1111, 4'b0000);
        for (int i = 0; i < 7; i++) apply(VEC[2], 1'b0, 4'b1111, 4'b0000);
        check(LW'(y_w[0 +: WW]), LW'(38'h2000000000), "R5");
        // R4 load after a long sum restarts from the product
        apply(VEC[3], 1'b1, 4'b1111, 4'b0000);
        check(y_m[LW +: LW], LW'(prod(VEC[3].a[1], VEC[3].b[1])), "R4");
        // R11 mid-run reset
        @(negedge clk); rst_n = 1'b0;
        apply(VEC[5], 1'b0, 4'b1111, 4'b0000);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule